// File: doc/BRIEF.md
# Cascaded Encoded Interrupt Controller

This block gathers level-sensitive interrupt requests from three urgency tiers and presents them to a processor as one encoded status word. The tiers are critical, main and peripheral. Each tier has a flag bit and a source-number field. The processor reads that word once and learns the single most urgent active source. It does not need to scan the request or mask registers.

The tiers are cascaded. Two codes in the upper tiers are not wired to request pins. Instead they report activity in the peripheral tier. Critical code 2 means "an urgent peripheral is pending", and main code 4 means "an ordinary peripheral is pending". In both cases the processor then reads the peripheral field to find the actual source. Peripheral code 0 is also not a pin: it stands for a group of up to 32 auxiliary (DMA) event sources. Those events are captured in a sticky pending register that the processor clears by writing ones.

The processor reaches the masks, the urgent-routing register, the auxiliary pending register, the status word and four priority-value registers through a simple register port. The port has a write strobe and a combinational read. Within a tier, the lowest-numbered active source always wins. The priority-value registers are storage only.

Top module: `casc_irq_ctrl`

## Requirements
- R1: After reset, the registers read as follows: peripheral mask (address 0) reads 0x7FFFFC00, main mask (address 1) reads 0x00010FFF, urgent routing (address 2) reads 0, auxiliary mask (address 3) reads 0xFFFFFFFF, auxiliary pending (address 4) reads 0 and status (address 5) reads 0. Both interrupt outputs are low.
- R2: Critical tier. Status bit 10 flags an active critical source, and bits 9:8 hold the lowest active source number. The critical sources are: source 0 on crit_req[0], source 1 on crit_req[1], and source 3 on crit_req[2]. Source 2 is active exactly when some pending peripheral has its urgent-routing bit (address 2, bit n for source n) set.
- R3: Main tier. Status bit 21 flags an active main source, and bits 20:16 hold the lowest active source number (0 to 16). main_req bit i drives source i for i < 4 and source i+1 for i >= 4. Source 4 is active exactly when some pending peripheral has its urgent bit clear. Main source n is disabled while main mask bit (16 - n) is 1.
- R4: Peripheral tier. Status bit 29 flags a pending peripheral, and bits 28:24 hold its number. If any urgent peripheral is pending, the field holds the lowest-numbered urgent one. Otherwise it holds the lowest-numbered pending one. peri_req[n] drives source n for n from 1 to 31. Source n is disabled while peripheral mask bit (31 - n) is 1. Source 0 is the auxiliary group.
- R5: Auxiliary group. Each cycle, aux_req bit n sets bit n of the sticky pending register (address 4). Writing a 1 to a bit of address 4 clears that bit. If a set and a clear hit the same bit in the same cycle, the set wins. Auxiliary bit n is disabled while auxiliary mask bit n is 1. Peripheral source 0 is pending while any enabled auxiliary bit is pending.
- R6: Precedence and outputs. irq_crit is high while status bit 10 is set. irq_cpu is high while status bit 21 or bit 29 is set. Every source-number field reads 0 while its flag is 0. All other status bits read 0.
- R7: Addresses 8 to 11 are four 32-bit priority-value registers that reset to 0. They read back what was written and have no effect on the status word or on the outputs.
- R8: A change on the request inputs shows in the status word and on the outputs after one rising clock edge. A register write shows in the status word one edge after the edge that stores it.
- R9: Reads of unmapped addresses (6, 7, 12 to 15) return 0. Writes to them, and writes to status address 5, change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| crit_req | input | 3 | Critical requests for sources 0, 1, 3 |
| main_req | input | 16 | Main requests, source 4 excluded |
| peri_req | input | 31 | Peripheral requests for sources 1 to 31 |
| aux_req | input | 32 | Auxiliary event inputs |
| irq_cpu | output | 1 | Ordinary interrupt to the processor |
| irq_crit | output | 1 | Critical interrupt to the processor |

## Verification
The hardest state to reach from the ports is a doubly cascaded one. In that state, an auxiliary bit is pending and enabled. That bit makes peripheral source 0 active, and source 0 in turn raises either main code 4 or critical code 2, depending on its urgent bit. At the same time, masks and other requests compete with it in every tier. A second hard case is a clear write that lands in the same cycle as a new event on the same auxiliary bit. The bench reaches both with directed sequences: single-source sweeps over every tier, and an auxiliary sweep with set and clear collisions. It then runs several hundred pseudo-random rounds. Each round rewrites all masks and the urgent register, pulses sparse auxiliary events and clears, and drives sparse requests. The bench compares the status word and both outputs against a model that it evaluates from the requirements.

// File: rtl/casc_irq_pkg.sv
package casc_irq_pkg;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;

  // register word addresses
  localparam logic [ADDR_W-1:0] A_PERI_MASK = 4'd0;
  localparam logic [ADDR_W-1:0] A_MAIN_MASK = 4'd1;
  localparam logic [ADDR_W-1:0] A_URGENT    = 4'd2;
  localparam logic [ADDR_W-1:0] A_AUX_MASK  = 4'd3;
  localparam logic [ADDR_W-1:0] A_AUX_PEND  = 4'd4;
  localparam logic [ADDR_W-1:0] A_STATUS    = 4'd5;
  localparam logic [ADDR_W-1:0] A_PRIO_BASE = 4'd8;

  // reset patterns (1 = source disabled)
  localparam logic [DATA_W-1:0] RST_PERI_MASK = 32'h7FFF_FC00;
  localparam logic [DATA_W-1:0] RST_MAIN_MASK = 32'h0001_0FFF;

  // status word layout
  localparam int ST_CRIT_FLAG = 10;
  localparam int ST_CRIT_LSB  = 8;
  localparam int ST_MAIN_FLAG = 21;
  localparam int ST_MAIN_LSB  = 16;
  localparam int ST_PERI_FLAG = 29;
  localparam int ST_PERI_LSB  = 24;

  // cascade codes
  localparam int CRIT_CASC = 2;
  localparam int MAIN_CASC = 4;
  localparam int PERI_AUX  = 0;

  // index of the lowest set bit, 0 when none is set
  function automatic logic [4:0] first_set(input logic [31:0] v);
    logic [4:0] r;
    r = '0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = 5'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/casc_irq_regs.sv
module casc_irq_regs
  import casc_irq_pkg::*;
#(
  parameter int MAIN_N = 17,
  parameter int PERI_N = 32,
  parameter int AUX_N  = 32,
  parameter int NPRIO  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  output logic [DATA_W-1:0]         peri_mask,
  output logic [MAIN_N-1:0]         main_mask,
  output logic [PERI_N-1:0]         urgent,
  output logic [AUX_N-1:0]          aux_mask,
  output logic [NPRIO-1:0][DATA_W-1:0] prio
);

  logic [DATA_W-1:0] peri_mask_d;
  logic [MAIN_N-1:0] main_mask_d;
  logic [PERI_N-1:0] urgent_d;
  logic [AUX_N-1:0]  aux_mask_d;
  logic              en_peri, en_main, en_urg, en_aux;

  always_comb begin
    en_peri     = wr_en && (wr_addr == A_PERI_MASK);
    en_main     = wr_en && (wr_addr == A_MAIN_MASK);
    en_urg      = wr_en && (wr_addr == A_URGENT);
    en_aux      = wr_en && (wr_addr == A_AUX_MASK);
    peri_mask_d = en_peri ? wr_data : peri_mask;
    main_mask_d = en_main ? wr_data[MAIN_N-1:0] : main_mask;
    urgent_d    = en_urg  ? wr_data[PERI_N-1:0] : urgent;
    aux_mask_d  = en_aux  ? wr_data[AUX_N-1:0]  : aux_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      peri_mask <= RST_PERI_MASK;
      main_mask <= RST_MAIN_MASK[MAIN_N-1:0];
      urgent    <= '0;
      aux_mask  <= '1;
    end else begin
      peri_mask <= peri_mask_d;
      main_mask <= main_mask_d;
      urgent    <= urgent_d;
      aux_mask  <= aux_mask_d;
    end
  end

  // priority values: stored for software, never used by the encoder
  for (genvar k = 0; k < NPRIO; k++) begin : g_prio
    logic              en_k;
    logic [DATA_W-1:0] prio_d;
    always_comb begin
      en_k   = wr_en && (wr_addr == A_PRIO_BASE + ADDR_W'(k));
      prio_d = en_k ? wr_data : prio[k];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prio[k] <= '0;
      else        prio[k] <= prio_d;
    end
  end

endmodule

// File: rtl/casc_irq_aux.sv
module casc_irq_aux
  import casc_irq_pkg::*;
#(
  parameter int AUX_N = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AUX_N-1:0] aux_req,
  input  logic             clr_en,
  input  logic [AUX_N-1:0] clr_bits,
  input  logic [AUX_N-1:0] aux_mask,
  output logic [AUX_N-1:0] aux_pend,
  output logic             aux_any
);

  logic [AUX_N-1:0] pend_d;
  logic [AUX_N-1:0] clr_vec;

  always_comb begin
    clr_vec = clr_en ? clr_bits : '0;
    // a new event outranks a clear of the same bit
    pend_d  = (aux_pend & ~clr_vec) | aux_req;
    aux_any = |(aux_pend & ~aux_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) aux_pend <= '0;
    else        aux_pend <= pend_d;
  end

endmodule

// File: rtl/casc_irq_encode.sv
module casc_irq_encode
  import casc_irq_pkg::*;
#(
  parameter int CRIT_N = 4,
  parameter int MAIN_N = 17,
  parameter int PERI_N = 32
) (
  input  logic [CRIT_N-2:0] crit_req,
  input  logic [MAIN_N-2:0] main_req,
  input  logic [PERI_N-1:1] peri_req,
  input  logic              aux_any,
  input  logic [DATA_W-1:0] peri_mask,
  input  logic [MAIN_N-1:0] main_mask,
  input  logic [PERI_N-1:0] urgent,
  output logic [DATA_W-1:0] status_d
);

  logic [PERI_N-1:0] peri_pend, peri_hi, peri_lo, peri_sel;
  logic [MAIN_N-1:0] main_pend;
  logic [CRIT_N-1:0] crit_pend;

  // peripheral tier: source n gated by mask bit (31 - n)
  for (genvar n = 0; n < PERI_N; n++) begin : g_peri
    if (n == PERI_AUX) begin : g_aux
      assign peri_pend[n] = aux_any & ~peri_mask[DATA_W-1-n];
    end else begin : g_pin
      assign peri_pend[n] = peri_req[n] & ~peri_mask[DATA_W-1-n];
    end
  end

  assign peri_hi  = peri_pend & urgent;
  assign peri_lo  = peri_pend & ~urgent;
  assign peri_sel = (|peri_hi) ? peri_hi : peri_pend;

  // main tier: source n gated by mask bit (MAIN_N-1 - n)
  for (genvar n = 0; n < MAIN_N; n++) begin : g_main
    if (n == MAIN_CASC) begin : g_casc
      assign main_pend[n] = (|peri_lo) & ~main_mask[MAIN_N-1-n];
    end else if (n < MAIN_CASC) begin : g_low
      assign main_pend[n] = main_req[n] & ~main_mask[MAIN_N-1-n];
    end else begin : g_high
      assign main_pend[n] = main_req[n-1] & ~main_mask[MAIN_N-1-n];
    end
  end

  // critical tier: not maskable
  for (genvar n = 0; n < CRIT_N; n++) begin : g_crit
    if (n == CRIT_CASC) begin : g_casc
      assign crit_pend[n] = |peri_hi;
    end else if (n < CRIT_CASC) begin : g_low
      assign crit_pend[n] = crit_req[n];
    end else begin : g_high
      assign crit_pend[n] = crit_req[n-1];
    end
  end

  always_comb begin
    status_d = '0;
    if (|crit_pend) begin
      status_d[ST_CRIT_FLAG] = 1'b1;
      status_d[ST_CRIT_LSB +: 2] = first_set(32'(crit_pend)) [1:0];
    end
    if (|main_pend) begin
      status_d[ST_MAIN_FLAG] = 1'b1;
      status_d[ST_MAIN_LSB +: 5] = first_set(32'(main_pend));
    end
    if (|peri_pend) begin
      status_d[ST_PERI_FLAG] = 1'b1;
      status_d[ST_PERI_LSB +: 5] = first_set(32'(peri_sel));
    end
  end

endmodule

// File: rtl/casc_irq_ctrl.sv
module casc_irq_ctrl
  import casc_irq_pkg::*;
#(
  parameter int CRIT_N = 4,
  parameter int MAIN_N = 17,
  parameter int PERI_N = 32,
  parameter int AUX_N  = 32,
  parameter int NPRIO  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [CRIT_N-2:0] crit_req,
  input  logic [MAIN_N-2:0] main_req,
  input  logic [PERI_N-1:1] peri_req,
  input  logic [AUX_N-1:0]  aux_req,
  output logic              irq_cpu,
  output logic              irq_crit
);

  logic [DATA_W-1:0]            peri_mask;
  logic [MAIN_N-1:0]            main_mask;
  logic [PERI_N-1:0]            urgent;
  logic [AUX_N-1:0]             aux_mask;
  logic [NPRIO-1:0][DATA_W-1:0] prio;
  logic [AUX_N-1:0]             aux_pend;
  logic                         aux_any;
  logic                         aux_clr;
  logic [DATA_W-1:0]            status_d, status_q;

  casc_irq_regs #(
    .MAIN_N(MAIN_N), .PERI_N(PERI_N), .AUX_N(AUX_N), .NPRIO(NPRIO)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .peri_mask(peri_mask), .main_mask(main_mask), .urgent(urgent),
    .aux_mask(aux_mask), .prio(prio)
  );

  assign aux_clr = wr_en && (wr_addr == A_AUX_PEND);

  casc_irq_aux #(.AUX_N(AUX_N)) u_aux (
    .clk(clk), .rst_n(rst_n), .aux_req(aux_req), .clr_en(aux_clr),
    .clr_bits(wr_data[AUX_N-1:0]), .aux_mask(aux_mask),
    .aux_pend(aux_pend), .aux_any(aux_any)
  );

  casc_irq_encode #(
    .CRIT_N(CRIT_N), .MAIN_N(MAIN_N), .PERI_N(PERI_N)
  ) u_enc (
    .crit_req(crit_req), .main_req(main_req), .peri_req(peri_req),
    .aux_any(aux_any), .peri_mask(peri_mask), .main_mask(main_mask),
    .urgent(urgent), .status_d(status_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  assign irq_crit = status_q[ST_CRIT_FLAG];
  assign irq_cpu  = status_q[ST_MAIN_FLAG] | status_q[ST_PERI_FLAG];

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      A_PERI_MASK: rd_data = peri_mask;
      A_MAIN_MASK: rd_data = DATA_W'(main_mask);
      A_URGENT:    rd_data = DATA_W'(urgent);
      A_AUX_MASK:  rd_data = DATA_W'(aux_mask);
      A_AUX_PEND:  rd_data = DATA_W'(aux_pend);
      A_STATUS:    rd_data = status_q;
      default: begin
        for (int k = 0; k < NPRIO; k++) begin
          if (rd_addr == A_PRIO_BASE + ADDR_W'(k)) rd_data = prio[k];
        end
      end
    endcase
  end

endmodule

// File: rtl/casc_irq_ctrl_chk.sv
module casc_irq_ctrl_chk #(
  parameter int AUX_N  = 32,
  parameter int MAIN_N = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [3:0]       wr_addr,
  input logic [31:0]      wr_data,
  input logic [AUX_N-1:0] aux_req,
  input logic [AUX_N-1:0] aux_pend,
  input logic [31:0]      status_q
);

  // R2: critical cascade code implies a pending peripheral
  p_crit_casc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[10] && status_q[9:8] == 2'd2) |-> status_q[29]);

  // R3: main cascade code implies a pending peripheral
  p_main_casc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[21] && status_q[20:16] == 5'd4) |-> status_q[29]);

  // R3: main source number stays inside the tier
  p_main_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[21] |-> (32'(status_q[20:16]) < MAIN_N));

  // R6: fields read zero while their flag is clear
  p_idle_fields_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_q[29] |-> status_q[28:24] == 5'd0) and
    (!status_q[21] |-> status_q[20:16] == 5'd0) and
    (!status_q[10] |-> status_q[9:8] == 2'd0));

  // R5: a write-one clear with no new event empties those bits
  p_aux_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 4'd4 && aux_req == '0) |=>
      ((aux_pend & $past(wr_data[AUX_N-1:0])) == '0));

  // R5: without a clear write, pending bits never drop
  p_aux_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == 4'd4) |=>
      ((aux_pend & $past(aux_pend)) == $past(aux_pend)));

endmodule

bind casc_irq_ctrl casc_irq_ctrl_chk #(.AUX_N(AUX_N), .MAIN_N(MAIN_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .aux_req(aux_req), .aux_pend(aux_pend), .status_q(status_q)
);

// File: tb/sim_casc_irq_ctrl.sv
`timescale 1ns/1ps
module sim_casc_irq_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [31:0] wr_data;
  logic [3:0]  rd_addr;
  logic [31:0] rd_data;
  logic [2:0]  crit_req;
  logic [15:0] main_req;
  logic [31:1] peri_req;
  logic [31:0] aux_req;
  logic        irq_cpu, irq_crit;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] seed = 32'h1D2C_3B4A;
  logic [31:0] m_pm, m_mm, m_urg, m_am, m_aux;

  always #4 clk = ~clk;

  casc_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .crit_req(crit_req), .main_req(main_req),
    .peri_req(peri_req), .aux_req(aux_req), .irq_cpu(irq_cpu), .irq_crit(irq_crit)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  function automatic logic [4:0] low(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return 5'(i);
    return 5'd0;
  endfunction

  // reference status word from the requirements
  function automatic logic [31:0] model(input logic [3:0] cr, input logic [16:0] mr,
                                        input logic [31:0] pr, input logic [31:0] ap);
    logic [31:0] pp, hi, lo, s;
    logic [16:0] mp;
    logic [3:0]  cp;
    pp = '0;
    for (int n = 0; n < 32; n++) begin
      logic src;
      src = (n == 0) ? |(ap & ~m_am) : pr[n];
      pp[n] = src & ~m_pm[31-n];
    end
    hi = pp & m_urg;
    lo = pp & ~m_urg;
    for (int n = 0; n < 17; n++) begin
      logic src;
      src = (n == 4) ? |lo : mr[n];
      mp[n] = src & ~m_mm[16-n];
    end
    cp = cr;
    cp[2] = |hi;
    s = '0;
    if (|cp) begin s[10] = 1'b1; s[9:8] = low(32'(cp)) [1:0]; end
    if (|mp) begin s[21] = 1'b1; s[20:16] = low(32'(mp)); end
    if (|pp) begin s[29] = 1'b1; s[28:24] = low((|hi) ? hi : pp); end
    return s;
  endfunction

  // drive per-source request vectors onto the packed ports
  task automatic drive(input logic [3:0] cr, input logic [16:0] mr, input logic [31:0] pr);
    crit_req = {cr[3], cr[1:0]};
    main_req = {mr[16:5], mr[3:0]};
    peri_req = pr[31:1];
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 4'd0) m_pm = d;
    if (a == 4'd1) m_mm = d & 32'h0001_FFFF;
    if (a == 4'd2) m_urg = d;
    if (a == 4'd3) m_am = d;
    if (a == 4'd4) m_aux = m_aux & ~d;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic pulse_aux(input logic [31:0] v);
    @(negedge clk);
    aux_req = v;
    @(negedge clk);
    aux_req = '0;
    m_aux = m_aux | v;
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic chk_st(input string req, input logic [31:0] exp);
    logic [31:0] d;
    rd(4'd5, d);
    chk(req, d, exp);
    chk(req, 32'(irq_crit), 32'(exp[10]));
    chk(req, 32'(irq_cpu), 32'(exp[21] | exp[29]));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main_seq
    logic [31:0] d;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    aux_req = '0;
    drive(4'd0, 17'd0, 32'd0);
    m_pm = 32'h7FFF_FC00; m_mm = 32'h0001_0FFF; m_urg = '0; m_am = '1; m_aux = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'd0, d); chk("R1 peri mask", d, 32'h7FFF_FC00);
    rd(4'd1, d); chk("R1 main mask", d, 32'h0001_0FFF);
    rd(4'd2, d); chk("R1 urgent", d, 32'h0);
    rd(4'd3, d); chk("R1 aux mask", d, 32'hFFFF_FFFF);
    rd(4'd4, d); chk("R1 aux pend", d, 32'h0);
    chk_st("R1 status", 32'h0);

    // R8 latency of a request change
    wr(4'd1, 32'h0);
    @(negedge clk);
    drive(4'd0, 17'h1_0000, 32'd0);
    rd(4'd5, d); chk("R8 before edge", d, 32'h0);
    @(negedge clk);
    rd(4'd5, d); chk("R8 after one edge", d, 32'h0030_0000);
    // R8 latency of a mask write
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd1; wr_data = 32'h1;
    @(negedge clk);
    wr_en = 1'b0; m_mm = 32'h1;
    rd(4'd5, d); chk("R8 write not yet visible", d, 32'h0030_0000);
    @(negedge clk);
    rd(4'd5, d); chk("R8 write visible", d, 32'h0);
    drive(4'd0, 17'd0, 32'd0);

    // R3 main sweep with peripherals fully masked
    wr(4'd0, 32'hFFFF_FFFF); wr(4'd1, 32'h0);
    for (int n = 0; n < 17; n++) begin
      drive(4'd0, 17'(1 << n), 32'd0);
      settle();
      chk_st("R3 main single", (n == 4) ? 32'h0 : (32'h0020_0000 | (32'(n) << 16)));
      wr(4'd1, 32'(1 << (16 - n)));
      settle();
      chk_st("R3 main masked", 32'h0);
      wr(4'd1, 32'h0);
    end
    drive(4'd0, 17'd0, 32'd0);

    // R2 critical sweep
    for (int n = 0; n < 4; n++) begin
      drive(4'(1 << n), 17'd0, 32'd0);
      settle();
      chk_st("R2 crit single", (n == 2) ? 32'h0 : (32'h0000_0400 | (32'(n) << 8)));
    end
    drive(4'd0, 17'd0, 32'd0);

    // R4 peripheral sweep, ordinary then urgent routing
    wr(4'd0, 32'h0);
    for (int n = 0; n < 32; n++) begin
      drive(4'd0, 17'd0, 32'(1) << n);
      settle();
      chk_st("R4 peri ordinary",
             (n == 0) ? 32'h0 : (32'h2000_0000 | (32'(n) << 24) | 32'h0024_0000));
      wr(4'd2, 32'hFFFF_FFFF);
      settle();
      chk_st("R2 peri urgent",
             (n == 0) ? 32'h0 : (32'h2000_0000 | (32'(n) << 24) | 32'h0000_0600));
      wr(4'd0, 32'(1) << (31 - n));
      settle();
      chk_st("R4 peri masked", 32'h0);
      wr(4'd0, 32'h0); wr(4'd2, 32'h0);
    end
    drive(4'd0, 17'd0, 32'd0);

    // R5 auxiliary group
    wr(4'd3, 32'h0);
    for (int k = 0; k < 32; k++) begin
      pulse_aux(32'(1) << k);
      settle();
      rd(4'd4, d); chk("R5 aux capture", d, 32'(1) << k);
      chk_st("R5 aux cascade", 32'h2000_0000 | 32'h0024_0000);
      wr(4'd3, 32'(1) << k);
      settle();
      chk_st("R5 aux masked", 32'h0);
      wr(4'd3, 32'h0);
      wr(4'd4, 32'(1) << k);
      settle();
      rd(4'd4, d); chk("R5 aux cleared", d, 32'h0);
    end
    // R5 set wins over clear in the same cycle
    pulse_aux(32'h0000_0011);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd4; wr_data = 32'h0000_0011; aux_req = 32'h0000_0001;
    @(negedge clk);
    wr_en = 1'b0; aux_req = '0; m_aux = 32'h1;
    rd(4'd4, d); chk("R5 set beats clear", d, 32'h0000_0001);
    wr(4'd4, 32'hFFFF_FFFF);

    // R7 priority registers store only
    for (int k = 0; k < 4; k++) begin
      wr(4'(8 + k), 32'hA5A5_0000 | 32'(k));
    end
    settle();
    for (int k = 0; k < 4; k++) begin
      rd(4'(8 + k), d); chk("R7 prio readback", d, 32'hA5A5_0000 | 32'(k));
    end
    chk_st("R7 no status effect", 32'h0);

    // R9 unmapped addresses and read-only status
    wr(4'd6, 32'hFFFF_FFFF); wr(4'd7, 32'hFFFF_FFFF); wr(4'd5, 32'hFFFF_FFFF);
    wr(4'd12, 32'hFFFF_FFFF);
    rd(4'd6, d);  chk("R9 unmapped read", d, 32'h0);
    rd(4'd13, d); chk("R9 unmapped read", d, 32'h0);
    rd(4'd0, d);  chk("R9 mask untouched", d, 32'h0);
    rd(4'd3, d);  chk("R9 aux mask untouched", d, 32'h0);
    rd(4'd5, d);  chk("R9 status untouched", d, 32'h0);

    // R6 random rounds across all tiers
    for (int it = 0; it < 300; it++) begin
      logic [3:0]  cr;
      logic [16:0] mr;
      logic [31:0] pr;
      wr(4'd0, rnd() | rnd());
      wr(4'd1, rnd() & rnd());
      wr(4'd2, rnd() & rnd());
      wr(4'd3, rnd() & rnd());
      wr(4'd4, rnd() & rnd());
      pulse_aux(rnd() & rnd() & rnd());
      cr = 4'(rnd() & rnd());
      mr = 17'(rnd() & rnd() & rnd());
      pr = rnd() & rnd() & rnd();
      drive(cr, mr, pr);
      settle();
      chk_st("R6 random mix", model(cr, mr, pr, m_aux));
      rd(4'd4, d); chk("R5 random pend", d, m_aux);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule